// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Burst Address Counters

This block is a true dual-port synchronous RAM. Port A and port B each have their own clock and reset. Either port can read or write any word, and both can reach the same word in the same cycle. A port registers its address, control and write data on the rising clock edge, then performs the access during the cycle that follows.

Each port has its own address counter. With the counter a port can run a burst of consecutive accesses after giving only one starting address. In any cycle the counter is cleared, loaded from the external address, advanced by one, or held, in that order of priority. A static mode pin picks the read latency:
- In flow-through mode, read data is on the output in the cycle after the sampling edge.
- In pipelined mode, an extra output register delays read data by one more clock.

Two chip selects (one active low, one active high) allow depth expansion. An active-low output enable gates the read data. When a port has nothing valid to show, its output sits at zero.

Top module: `dual_port_burst_ram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits, 9 bits by default; ADDR_W = 13 gives 8K words. A word written through either port is returned by a later read of that address through either port.
- R2: Suppose one port writes an address in the same cycle that the other port reads it. The read returns the previous contents. A read of that address in the next cycle returns the new word.
- R3: In flow-through mode (`x_pipe` = 0), read data for inputs sampled at edge k is on `x_dout` after edge k and holds until edge k+1.
- R4: In pipelined mode (`x_pipe` = 1), read data for inputs sampled at edge k first appears after edge k+1, one clock later than in flow-through mode.
- R5: When `x_clr_n` is low, the access in that cycle uses address 0 and the counter becomes 0. A read or write at address 0 proceeds in the same cycle.
- R6: When `x_clr_n` is high and `x_load_n` is low, the access uses `x_addr` and the counter takes that value.
- R7: When `x_clr_n` and `x_load_n` are high and `x_step_n` is low, the access uses the counter value plus one. The counter advances, wrapping from 2**ADDR_W-1 to 0.
- R8: When `x_clr_n`, `x_load_n` and `x_step_n` are all high, the access reuses the counter value and `x_addr` is ignored.
- R9: Counter priority is clear, then load, then step, then hold.
- R10: A port is selected only when `x_cs_n` = 0 and `x_cs` = 1. A deselected port neither writes nor drives read data: `x_dout` is 0. Its counter still follows R5 to R8, and the output is 0 after reset.
- R11: `x_oe_n` is sampled with the read. When it is high, `x_dout` shows 0 for that read and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A reset, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_din | input | DATA_W | Port A write data |
| a_wr | input | 1 | Port A access type, 1 = write, 0 = read |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_load_n | input | 1 | Port A address load strobe, active low |
| a_step_n | input | 1 | Port A counter advance, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_pipe | input | 1 | Port A read latency, 1 = pipelined (static) |
| a_dout | output | DATA_W | Port A read data, 0 when idle |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B reset, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_din | input | DATA_W | Port B write data |
| b_wr | input | 1 | Port B access type, 1 = write, 0 = read |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_load_n | input | 1 | Port B address load strobe, active low |
| b_step_n | input | 1 | Port B counter advance, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_pipe | input | 1 | Port B read latency, 1 = pipelined (static) |
| b_dout | output | DATA_W | Port B read data, 0 when idle |

## Verification
The bench targets these corner cases, and for each names the failure a faulty design would show:
- **Counter priority.** The bench asserts clear together with load, and load together with step. A wrong priority order reads the wrong word.
- **Counter wrap.** A step from the top address must land on word 0. A counter that saturates or carries into a wider register would instead overwrite some other word.
- **Hold and deselect.** A hold cycle drives a different external address, and the counter is loaded while the port is deselected. A design that leaks the external address into a hold, or freezes the counter on deselect, returns wrong data.
- **Write/read collision.** One port reads an address in the same cycle the other port writes it. A design that forwards the new word early, or loses it, fails the old-then-new sequence.
- **Latency.** Pipelined reads are sampled both one and two edges after the request, which catches a missing or doubled output stage.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Counter operation chosen for one cycle, highest priority first.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } ctr_op_e;

  // Priority decode of the three active-low counter controls.
  function automatic ctr_op_e pick_op(input logic clr_n, input logic load_n,
                                      input logic step_n);
    if (!clr_n)       return OP_CLEAR;
    else if (!load_n) return OP_LOAD;
    else if (!step_n) return OP_STEP;
    return OP_HOLD;
  endfunction

  // A port is live only with both selects in their active state.
  function automatic logic port_live(input logic cs_n, input logic cs);
    return !cs_n && cs;
  endfunction

endpackage

// File: rtl/dpr_bank.sv
// One storage bank with a single writer and two asynchronous read taps.
module dpr_bank #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  output logic [DATA_W-1:0] rdata0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata0 = cells[raddr0];
  assign rdata1 = cells[raddr1];

endmodule

// File: rtl/dpr_addr_ctr.sv
// Burst address counter. cnt_q holds the address used last cycle.
module dpr_addr_ctr
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctr_op_e           op,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam logic [ADDR_W-1:0] ZERO = '0;

  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] cnt_q;

  always_comb begin
    unique case (op)
      OP_CLEAR: acc_addr = ZERO;
      OP_LOAD:  acc_addr = ext_addr;
      OP_STEP:  acc_addr = advance(cnt_q);
      default:  acc_addr = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= acc_addr;
  end

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_STEP |-> acc_addr == $past(acc_addr) + ADDR_W'(1));

  // R8
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |-> acc_addr == $past(acc_addr));

  // R5
  clear_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op) == OP_CLEAR) && (op == OP_HOLD) |-> acc_addr == ZERO);

endmodule

// File: rtl/dpr_port.sv
// One port: input registers, counter, select decode and read output path.
module dpr_port
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              oe_n,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clr_n,
  input  logic              pipe,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_fire,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] IDLE = '0;

  // Registered port inputs
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              wr_q, cs_n_q, cs_q, oe_n_q, load_n_q, step_n_q, clr_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      din_q    <= '0;
      wr_q     <= 1'b0;
      cs_n_q   <= 1'b1;
      cs_q     <= 1'b0;
      oe_n_q   <= 1'b1;
      load_n_q <= 1'b1;
      step_n_q <= 1'b1;
      clr_n_q  <= 1'b1;
    end else begin
      addr_q   <= addr;
      din_q    <= din;
      wr_q     <= wr;
      cs_n_q   <= cs_n;
      cs_q     <= cs;
      oe_n_q   <= oe_n;
      load_n_q <= load_n;
      step_n_q <= step_n;
      clr_n_q  <= clr_n;
    end
  end

  // Named internal events
  ctr_op_e op;
  logic    live, rd_fire, rd_show;

  assign op      = pick_op(clr_n_q, load_n_q, step_n_q);
  assign live    = port_live(cs_n_q, cs_q);
  assign wr_fire = live && wr_q;
  assign rd_fire = live && !wr_q;
  assign rd_show = rd_fire && !oe_n_q;
  assign wr_data = din_q;

  dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .ext_addr (addr_q),
    .acc_addr (acc_addr)
  );

  // Read path: flow-through word, optionally one more register.
  logic [DATA_W-1:0] ft_word, pipe_q;

  assign ft_word = rd_show ? rd_word : IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= IDLE;
    else        pipe_q <= ft_word;
  end

  assign dout = pipe ? pipe_q : ft_word;

  // R10
  desel_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n || !cs) |-> !wr_fire);

  // R10
  desel_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe && $past(cs_n || !cs) |-> dout == IDLE);

  // R11
  oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe && $past(oe_n, 2) |-> dout == IDLE);

  // R4
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe && $past(rd_show) |-> dout == $past(rd_word));

endmodule

// File: rtl/dual_port_burst_ram.sv
// Top level: two ports over a pair of single-writer banks whose XOR is the stored word.
module dual_port_burst_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  input  logic              a_wr,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_oe_n,
  input  logic              a_load_n,
  input  logic              a_step_n,
  input  logic              a_clr_n,
  input  logic              a_pipe,
  output logic [DATA_W-1:0] a_dout,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  input  logic              b_wr,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_oe_n,
  input  logic              b_load_n,
  input  logic              b_step_n,
  input  logic              b_clr_n,
  input  logic              b_pipe,
  output logic [DATA_W-1:0] b_dout
);
  // Stored word = bank A cell XOR bank B cell.
  function automatic logic [DATA_W-1:0] mix(input logic [DATA_W-1:0] x,
                                            input logic [DATA_W-1:0] y);
    return x ^ y;
  endfunction

  logic [ADDR_W-1:0] a_acc, b_acc;
  logic              a_wr_fire, b_wr_fire;
  logic [DATA_W-1:0] a_wr_data, b_wr_data;
  logic [DATA_W-1:0] a_rd_word, b_rd_word;
  logic [DATA_W-1:0] bka_at_a, bka_at_b, bkb_at_a, bkb_at_b;

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
    .clk (a_clk), .rst_n (a_rst_n), .addr (a_addr), .din (a_din), .wr (a_wr),
    .cs_n (a_cs_n), .cs (a_cs), .oe_n (a_oe_n), .load_n (a_load_n),
    .step_n (a_step_n), .clr_n (a_clr_n), .pipe (a_pipe),
    .acc_addr (a_acc), .wr_fire (a_wr_fire), .wr_data (a_wr_data),
    .rd_word (a_rd_word), .dout (a_dout)
  );

  dpr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
    .clk (b_clk), .rst_n (b_rst_n), .addr (b_addr), .din (b_din), .wr (b_wr),
    .cs_n (b_cs_n), .cs (b_cs), .oe_n (b_oe_n), .load_n (b_load_n),
    .step_n (b_step_n), .clr_n (b_clr_n), .pipe (b_pipe),
    .acc_addr (b_acc), .wr_fire (b_wr_fire), .wr_data (b_wr_data),
    .rd_word (b_rd_word), .dout (b_dout)
  );

  // Bank A: written only by port A
  dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_a (
    .clk (a_clk), .we (a_wr_fire), .waddr (a_acc),
    .wdata (mix(a_wr_data, bkb_at_a)),
    .raddr0 (a_acc), .rdata0 (bka_at_a),
    .raddr1 (b_acc), .rdata1 (bka_at_b)
  );

  // Bank B: written only by port B
  dpr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_b (
    .clk (b_clk), .we (b_wr_fire), .waddr (b_acc),
    .wdata (mix(b_wr_data, bka_at_b)),
    .raddr0 (a_acc), .rdata0 (bkb_at_a),
    .raddr1 (b_acc), .rdata1 (bkb_at_b)
  );

  assign a_rd_word = mix(bka_at_a, bkb_at_a);
  assign b_rd_word = mix(bka_at_b, bkb_at_b);

endmodule

// File: tb/dual_port_burst_ram_bench.sv
module dual_port_burst_ram_bench;
  localparam int AW = 10;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_din, b_din, a_dout, b_dout;
  logic a_wr, a_cs_n, a_cs, a_oe_n, a_load_n, a_step_n, a_clr_n, a_pipe;
  logic b_wr, b_cs_n, b_cs, b_oe_n, b_load_n, b_step_n, b_clr_n, b_pipe;

  dual_port_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dual_port_burst_ram (
    .a_clk (clk), .a_rst_n (rst_n), .a_addr (a_addr), .a_din (a_din), .a_wr (a_wr),
    .a_cs_n (a_cs_n), .a_cs (a_cs), .a_oe_n (a_oe_n), .a_load_n (a_load_n),
    .a_step_n (a_step_n), .a_clr_n (a_clr_n), .a_pipe (a_pipe), .a_dout (a_dout),
    .b_clk (clk), .b_rst_n (rst_n), .b_addr (b_addr), .b_din (b_din), .b_wr (b_wr),
    .b_cs_n (b_cs_n), .b_cs (b_cs), .b_oe_n (b_oe_n), .b_load_n (b_load_n),
    .b_step_n (b_step_n), .b_clr_n (b_clr_n), .b_pipe (b_pipe), .b_dout (b_dout)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_set(input logic clr_n, input logic load_n, input logic step_n,
                       input logic sel, input logic wr, input logic [AW-1:0] addr,
                       input logic [DW-1:0] din);
    a_clr_n = clr_n; a_load_n = load_n; a_step_n = step_n;
    a_cs_n = !sel; a_cs = sel; a_wr = wr; a_addr = addr; a_din = din; a_oe_n = 1'b0;
  endtask

  task automatic b_set(input logic clr_n, input logic load_n, input logic step_n,
                       input logic sel, input logic wr, input logic [AW-1:0] addr,
                       input logic [DW-1:0] din);
    b_clr_n = clr_n; b_load_n = load_n; b_step_n = step_n;
    b_cs_n = !sel; b_cs = sel; b_wr = wr; b_addr = addr; b_din = din; b_oe_n = 1'b0;
  endtask

  // Stimulus/expectation vector for port A in flow-through mode
  typedef struct packed {
    logic [3:0]    req;
    logic          clr_n, load_n, step_n, sel, wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TABLE [NV] = '{
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd5,    9'h011, 9'h000},
    '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0,    9'h022, 9'h000},
    '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0,    9'h033, 9'h000},
    '{4'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,    9'h000, 9'h011},
    '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0,    9'h000, 9'h022},
    '{4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 10'd100,  9'h000, 9'h022},
    '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0,    9'h000, 9'h033},
    '{4'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 10'd9,    9'h044, 9'h000},
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd7,    9'h000, 9'h033},
    '{4'd9,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5,    9'h000, 9'h044},
    '{4'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'd5,    9'h000, 9'h011},
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd1023, 9'h155, 9'h000},
    '{4'd7,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 10'd0,    9'h0AA, 9'h000},
    '{4'd7,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd0,    9'h000, 9'h0AA},
    '{4'd5,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 10'd3,    9'h000, 9'h0AA},
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd1023, 9'h000, 9'h155},
    '{4'd10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 10'd6,    9'h1FF, 9'h000},
    '{4'd10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 10'd200,  9'h000, 9'h022}
  };

  function automatic string req_tag(input logic [3:0] n);
    case (n)
      4'd3:    return "R3 flow-through read";
      4'd5:    return "R5 counter clear";
      4'd6:    return "R6 address load";
      4'd7:    return "R7 counter step/wrap";
      4'd8:    return "R8 counter hold";
      4'd9:    return "R9 control priority";
      default: return "R10 select";
    endcase
  endfunction

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    a_pipe = 1'b0;
    b_pipe = 1'b1;
    a_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    b_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset output A", a_dout, 9'h000);
    check("R10 reset output B", b_dout, 9'h000);
    rst_n = 1'b1;
    @(posedge clk);

    // Vector table on port A
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check(req_tag(TABLE[i-1].req), a_dout, TABLE[i-1].exp);
      a_set(TABLE[i].clr_n, TABLE[i].load_n, TABLE[i].step_n, TABLE[i].sel,
            TABLE[i].wr, TABLE[i].addr, TABLE[i].din);
      @(posedge clk);
    end
    @(negedge clk);
    check(req_tag(TABLE[NV-1].req), a_dout, TABLE[NV-1].exp);
    a_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);

    // R4: pipelined read on port B of word 5 written by port A
    b_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, '0);
    @(posedge clk); @(negedge clk);
    check("R4 pipelined not yet after first edge", b_dout, 9'h000);
    b_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    @(posedge clk); @(negedge clk);
    check("R4 pipelined data after second edge", b_dout, 9'h011);

    // R1: port B writes, port A reads back
    b_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd9, 9'h0C3);
    @(posedge clk); @(negedge clk);
    b_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    a_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd9, '0);
    @(posedge clk); @(negedge clk);
    check("R1 cross-port readback", a_dout, 9'h0C3);

    // R2: same-cycle write on A and read on B of word 20
    a_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd20, 9'h012);
    @(posedge clk); @(negedge clk);
    a_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd20, 9'h077);
    b_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd20, '0);
    @(posedge clk); @(negedge clk);
    a_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    b_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd20, '0);
    @(posedge clk); @(negedge clk);
    check("R2 collision read returns old word", b_dout, 9'h012);
    b_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    @(posedge clk); @(negedge clk);
    check("R2 next read returns new word", b_dout, 9'h077);

    // R11: output enable off, then on
    a_set(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'd5, '0);
    a_oe_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 output disabled shows idle", a_dout, 9'h000);
    a_oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 memory unchanged after disabled read", a_dout, 9'h011);
    a_set(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    @(posedge clk); @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule